// File: doc/BRIEF.md
# SPI Interrupt and TX Watermark Unit

This block keeps the interrupt state of a SPI controller. It tracks how many entries sit in the transmit FIFO by counting push and pop strobes. From that count it raises a transmit full condition and a below-watermark event. It also latches a mode-fault event and follows a not-empty level from the receive FIFO. Each status bit is gated by a mask, and the gated bits are ORed into a single level interrupt line.

Software reaches the block through a flat register port with fixed offsets. The mask is never written directly: one write-only offset sets mask bits and another clears them, and a separate read-only offset returns the current mask. The watermark threshold register stores only log2(DEPTH) bits. Writing all ones and reading the value back therefore tells software the FIFO depth minus one. The FIFO storage and the serial shifter live outside this block.

Top module: `spi_irq_wm_unit`

## Requirements
- R1: After reset the status reads 0, the mask reads 0, the threshold reads 1 and `irq_o` is low.
- R2: The TX occupancy count rises by one on an accepted push and falls by one on an accepted pop. A push while the count equals DEPTH is ignored. A pop while the count is 0 is ignored. An accepted push and an accepted pop in the same cycle leave the count unchanged.
- R3: Status bit 1 (mode fault) is set by a `mode_fault_i` pulse and stays set until it is cleared by a write to the status offset. When the event and the clear fall in the same cycle, the bit stays set.
- R4: Status bit 2 (TX below watermark) is set one cycle after the occupancy changes from at least the threshold to below it. A threshold write can also cause this change. The bit stays set until cleared, even while the occupancy remains below the threshold.
- R5: Status bit 3 (TX full) is set in every cycle that follows a cycle with occupancy equal to DEPTH. Clearing it has no lasting effect while the FIFO stays full.
- R6: Status bit 4 (RX not empty) is set in every cycle that follows a cycle with `rx_not_empty_i` high. Clearing it has no lasting effect while the input stays high.
- R7: A write to offset 0x08 sets every mask bit whose write bit is 1. A write to offset 0x0C clears every mask bit whose write bit is 1. Zero bits leave the mask alone. Offset 0x10 reads the 7-bit mask, and offsets 0x08 and 0x0C read 0.
- R8: Offset 0x04 reads the status. Writing a 1 to a status bit clears it and writing a 0 leaves it. Bits 0, 5 and 6 always read 0.
- R9: Offset 0x28 holds the threshold, which is log2(DEPTH) bits wide. A write keeps only the low bits, so writing 0xFFFF reads back as DEPTH-1.
- R10: `irq_o` is high exactly when some bit is set in both the status and the mask.
- R11: Any other offset reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| tx_push_i | input | 1 | TX FIFO push strobe |
| tx_pop_i | input | 1 | TX FIFO pop strobe |
| rx_not_empty_i | input | 1 | RX FIFO not-empty level |
| mode_fault_i | input | 1 | Mode-fault event pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following:
- the occupancy count stays within bounds and moves by exactly one on a lone push or a lone pop;
- each event reaches its status bit on the next cycle;
- enable and disable writes land in the mask;
- threshold writes are truncated;
- an all-zero mask keeps the interrupt low.

Other properties only show up across a sequence of operations, so the bench scenarios check them. These are: pushes ignored at full (seen as the FIFO refilling after a single push), the set-over-clear priority, the watermark being an edge rather than a level, and the re-assertion of level bits after a clear.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NSTAT   = 7;
  localparam int B_MODF  = 1;
  localparam int B_TXLOW = 2;
  localparam int B_TXFUL = 3;
  localparam int B_RXNE  = 4;
  localparam logic [NSTAT-1:0] LIVE_BITS = 7'h1E;

  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_MSET   = 8'h08;
  localparam logic [7:0] OFS_MCLR   = 8'h0C;
  localparam logic [7:0] OFS_MASK   = 8'h10;
  localparam logic [7:0] OFS_THRESH = 8'h28;

  function automatic logic [NSTAT-1:0] pack_events(logic modf, logic txlow,
                                                   logic txful, logic rxne);
    logic [NSTAT-1:0] v;
    v = '0;
    v[B_MODF]  = modf;
    v[B_TXLOW] = txlow;
    v[B_TXFUL] = txful;
    v[B_RXNE]  = rxne;
    return v;
  endfunction

  function automatic logic [NSTAT-1:0] clear_then_set(logic [NSTAT-1:0] cur,
                                                      logic [NSTAT-1:0] clr,
                                                      logic [NSTAT-1:0] set);
    return ((cur & ~clr) | set) & LIVE_BITS;
  endfunction
endpackage

// File: rtl/spi_txlvl_ctr.sv
module spi_txlvl_ctr #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] thr_i,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          below_o
);
  logic inc_ok, dec_ok;

  assign full_o  = (level_o == CW'(DEPTH));
  assign inc_ok  = push_i & ~full_o;
  assign dec_ok  = pop_i & (level_o != '0);
  assign below_o = (level_o < CW'(thr_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                level_o <= '0;
    else if (inc_ok && !dec_ok) level_o <= level_o + 1'b1;
    else if (dec_ok && !inc_ok) level_o <= level_o - 1'b1;
  end

  a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= CW'(DEPTH));
  a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> level_o == CW'($past(level_o) + 1'b1));
  a_r2_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && level_o != '0) |=> level_o == CW'($past(level_o) - 1'b1));
  a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> $stable(level_o));
endmodule

// File: rtl/spi_wm_thresh.sv
module spi_wm_thresh #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [31:0]   wdata_i,
  output logic [AW-1:0] thr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    thr_o <= AW'(1);
    else if (wr_i) thr_o <= wdata_i[AW-1:0];
  end

  a_r9_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> thr_o == $past(wdata_i[AW-1:0]));
endmodule

// File: rtl/spi_irq_stat.sv
module spi_irq_stat
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             modf_i,
  input  logic             full_i,
  input  logic             below_i,
  input  logic             rxne_i,
  input  logic             clr_we_i,
  input  logic             set_we_i,
  input  logic             dis_we_i,
  input  logic [NSTAT-1:0] bits_i,
  output logic [NSTAT-1:0] stat_o,
  output logic [NSTAT-1:0] mask_o,
  output logic             irq_o
);
  logic             below_q;
  logic             low_event;
  logic [NSTAT-1:0] ev_vec, clr_vec;

  assign low_event = below_i & ~below_q;
  assign ev_vec    = pack_events(modf_i, low_event, full_i, rxne_i);
  assign clr_vec   = clr_we_i ? bits_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      below_q <= 1'b1;
      stat_o  <= '0;
      mask_o  <= '0;
    end else begin
      below_q <= below_i;
      stat_o  <= clear_then_set(stat_o, clr_vec, ev_vec);
      if (set_we_i)      mask_o <= mask_o | bits_i;
      else if (dis_we_i) mask_o <= mask_o & ~bits_i;
    end
  end

  assign irq_o = |(stat_o & mask_o);

  a_r3_modf_set: assert property (@(posedge clk) disable iff (!rst_n)
    modf_i |=> stat_o[B_MODF]);
  a_r4_low_set: assert property (@(posedge clk) disable iff (!rst_n)
    low_event |=> stat_o[B_TXLOW]);
  a_r5_full_set: assert property (@(posedge clk) disable iff (!rst_n)
    full_i |=> stat_o[B_TXFUL]);
  a_r6_rxne_set: assert property (@(posedge clk) disable iff (!rst_n)
    rxne_i |=> stat_o[B_RXNE]);
  a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> ((mask_o & $past(bits_i)) == $past(bits_i)));
  a_r7_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    dis_we_i |=> ((mask_o & $past(bits_i)) == '0));
  a_r8_dead_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o & ~LIVE_BITS) == '0);
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == '0) |-> !irq_o);
endmodule

// File: rtl/spi_irq_wm_unit.sv
module spi_irq_wm_unit
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        tx_push_i,
  input  logic        tx_pop_i,
  input  logic        rx_not_empty_i,
  input  logic        mode_fault_i,
  output logic        irq_o
);
  initial begin
    a_depth_pow2: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("DEPTH must be a power of two");
  end

  logic             wr_stat, wr_mset, wr_mclr, wr_thr;
  logic [AW-1:0]    thr;
  logic [CW-1:0]    level;
  logic             lvl_full, lvl_below;
  logic [NSTAT-1:0] stat, mask;

  assign wr_stat = reg_wr_i && (reg_addr_i == OFS_STATUS);
  assign wr_mset = reg_wr_i && (reg_addr_i == OFS_MSET);
  assign wr_mclr = reg_wr_i && (reg_addr_i == OFS_MCLR);
  assign wr_thr  = reg_wr_i && (reg_addr_i == OFS_THRESH);

  spi_wm_thresh #(.AW(AW)) thr_i (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_thr), .wdata_i(reg_wdata_i), .thr_o(thr)
  );

  spi_txlvl_ctr #(.DEPTH(DEPTH)) lvl_i (
    .clk(clk), .rst_n(rst_n), .push_i(tx_push_i), .pop_i(tx_pop_i),
    .thr_i(thr), .level_o(level), .full_o(lvl_full), .below_o(lvl_below)
  );

  spi_irq_stat stat_i (
    .clk(clk), .rst_n(rst_n), .modf_i(mode_fault_i), .full_i(lvl_full),
    .below_i(lvl_below), .rxne_i(rx_not_empty_i), .clr_we_i(wr_stat),
    .set_we_i(wr_mset), .dis_we_i(wr_mclr), .bits_i(reg_wdata_i[NSTAT-1:0]),
    .stat_o(stat), .mask_o(mask), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_STATUS: reg_rdata_o = 32'(stat);
      OFS_MASK:   reg_rdata_o = 32'(mask);
      OFS_THRESH: reg_rdata_o = 32'(thr);
      default:    reg_rdata_o = '0;
    endcase
  end

  a_r11_dead_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 8'h14) |=> $stable(mask));
endmodule

// File: tb/spi_irq_wm_unit_tb_top.sv
module spi_irq_wm_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        push = 1'b0, pop = 1'b0, rxne = 1'b0, modf = 1'b0;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_wm_unit #(.DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .tx_push_i(push),
    .tx_pop_i(pop), .rx_not_empty_i(rxne), .mode_fault_i(modf), .irq_o(irq)
  );

  int total = 0, bad = 0;
  int m_cnt = 0, m_thr = 1, m_stat = 0, m_mask = 0;
  bit m_bprev = 1'b1;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_read(int a);
    case (a)
      4:  return m_stat;
      16: return m_mask;
      40: return m_thr;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      4: return "R8 status";
      8, 12, 16: return "R7 mask";
      40: return "R9 thresh";
      default: return "R11 unmapped";
    endcase
  endfunction

  task automatic model_step(bit pu, bit po, bit rx, bit mf, bit wr, int a, int wd);
    bit full, below;
    int set, clr;
    full  = (m_cnt == D);
    below = (m_cnt < m_thr);
    set = 0;
    if (mf) set |= 2;
    if (below && !m_bprev) set |= 4;
    if (full) set |= 8;
    if (rx) set |= 16;
    clr = (wr && a == 4) ? (wd & 'h7f) : 0;
    if (wr && a == 8)  m_mask = m_mask | (wd & 'h7f);
    if (wr && a == 12) m_mask = m_mask & ~wd & 'h7f;
    if (wr && a == 40) m_thr = wd & (D - 1);
    if (pu && !full && !(po && m_cnt != 0)) m_cnt++;
    else if (po && m_cnt != 0 && !(pu && !full)) m_cnt--;
    m_bprev = below;
    m_stat = ((m_stat & ~clr) | set) & 'h1e;
  endtask

  task automatic cyc(bit pu, bit po, bit rx, bit mf, bit wr, int a, int wd);
    @(negedge clk);
    push = pu; pop = po; rxne = rx; modf = mf;
    reg_wr = wr; reg_addr = a[7:0]; reg_wdata = wd;
    @(posedge clk);
    model_step(pu, po, rx, mf, wr, a, wd);
    #(CLK_PERIOD/4);
    chk("R10 irq", int'(irq), int'((m_stat & m_mask) != 0));
    chk(tag_of(a), int'(reg_rdata), exp_read(a));
  endtask

  task automatic rd(int a, bit rx = 0);
    cyc(0, 0, rx, 0, 0, a, 0);
  endtask

  task automatic wr(int a, int wd, bit rx = 0);
    cyc(0, 0, rx, 0, 1, a, wd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int addrs[6] = '{4, 8, 12, 16, 40, 20};
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    chk("R1 status", int'(reg_rdata), 0);
    chk("R1 irq", int'(irq), 0);
    rd(16); chk("R1 mask", int'(reg_rdata), 0);
    rd(40); chk("R1 thresh", int'(reg_rdata), 1);

    wr(40, 'hffff); rd(40); chk("R9 depth probe", int'(reg_rdata), D - 1);
    wr(40, 4);
    wr(4, 'h7f);
    for (int i = 0; i < D; i++) cyc(1, 0, 0, 0, 0, 4, 0);
    rd(4); chk("R5 full set", int'(reg_rdata[3]), 1);
    cyc(1, 0, 0, 0, 0, 4, 0); cyc(1, 0, 0, 0, 0, 4, 0);
    wr(4, 'h1e); rd(4); chk("R5 full reasserts", int'(reg_rdata[3]), 1);
    cyc(0, 1, 0, 0, 0, 4, 0);
    wr(4, 'h1e); rd(4); chk("R2 full gone after pop", int'(reg_rdata[3]), 0);
    cyc(1, 0, 0, 0, 0, 4, 0); rd(4);
    chk("R2 extra pushes ignored", int'(reg_rdata[3]), 1);

    wr(4, 'h7f);
    for (int i = 0; i < D - 4; i++) cyc(0, 1, 0, 0, 0, 4, 0);
    rd(4); chk("R4 at threshold", int'(reg_rdata[2]), 0);
    cyc(0, 1, 0, 0, 0, 4, 0); rd(4);
    chk("R4 crossing sets", int'(reg_rdata[2]), 1);
    wr(4, 'h04); rd(4); rd(4);
    chk("R4 edge not level", int'(reg_rdata[2]), 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, 4, 0);
    cyc(0, 1, 0, 0, 0, 4, 0);
    rd(4);

    wr(4, 'h7f);
    cyc(0, 0, 0, 1, 0, 4, 0); rd(4);
    chk("R3 modf set", int'(reg_rdata[1]), 1);
    wr(4, 'h1c); rd(4); chk("R8 zero bits keep", int'(reg_rdata[1]), 1);
    cyc(0, 0, 0, 1, 1, 4, 2); rd(4);
    chk("R3 set beats clear", int'(reg_rdata[1]), 1);
    wr(4, 2); rd(4); chk("R3 cleared", int'(reg_rdata[1]), 0);

    wr(4, 'h10, 1); rd(4, 1);
    chk("R6 rxne reasserts", int'(reg_rdata[4]), 1);
    wr(4, 'h10, 0); rd(4);
    chk("R6 rxne cleared", int'(reg_rdata[4]), 0);

    wr(8, 'h12); rd(16); chk("R7 enable", int'(reg_rdata), 'h12);
    rd(8); chk("R7 enable reads zero", int'(reg_rdata), 0);
    wr(12, 'h02); rd(16); chk("R7 disable", int'(reg_rdata), 'h10);
    cyc(0, 0, 1, 0, 0, 4, 0); rd(4, 1);
    chk("R10 irq up", int'(irq), 1);
    wr(12, 'h10, 1); chk("R10 irq masked", int'(irq), 0);
    wr(4, 'h7f);
    wr(20, 'h7f); rd(16); chk("R11 write ignored", int'(reg_rdata), 0);
    rd(20); chk("R11 read zero", int'(reg_rdata), 0);

    for (int i = 0; i < 4000; i++) begin
      bit pu, po, rx, mf, w;
      int a, wd;
      pu = (i % 1000 < 500) ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
      po = (i % 1000 < 500) ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
      rx = ($urandom % 3 == 0);
      mf = ($urandom % 40 == 0);
      w  = ($urandom % 6 == 0);
      a  = addrs[$urandom % 6];
      wd = (a == 40) ? ($urandom % D) : int'($urandom);
      cyc(pu, po, rx, mf, w, a, wd);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule